// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block is a passive, synchronous monitor placed on the command bus between a memory controller and a four-bank SDRAM. On every rising clock edge it turns the active-low chip-select, row-strobe, column-strobe and write-enable pins, together with the bank-select bits and the auto-precharge address bit, into one command. It keeps its own model of which banks hold an open row, which burst length the mode register was last programmed with, whether a read or write burst with auto precharge is still running, and whether the short quiet period after a mode-register write is still in force.

When a command arrives in a state where it is not allowed, the checker raises a violation flag for one cycle, together with an error code that names the broken rule. An illegal command is treated as if the memory had refused it, so the model stays where it was. Legal commands move the model forward: activate opens a bank, precharge closes one or all banks, a mode-register write latches a new burst length, and an auto-precharge burst closes its bank by itself once its last beat has gone by.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With cs_n high the command is deselect, and with {cs_n,ras_n,cas_n,we_n}=0111 it is no-operation; neither is ever flagged. The remaining encodings are 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh (auto refresh and self-refresh entry), 0000 mode-register write, 0110 burst stop. viol and viol_code are registered: a command sampled at edge t shows its verdict after edge t, for one cycle.
- R2: ba selects bank 0..3 (00, 01, 10, 11). Activate to a bank that holds an open row gives code 4; activate to a closed bank is legal and opens it.
- R3: A read or write to a closed bank gives code 5.
- R4: Precharge with addr[10]=0 closes only the bank selected by ba; with addr[10]=1 it closes all four banks whatever ba holds. A legal precharge that hits the bank of a running auto-precharge burst ends that burst.
- R5: A mode-register write while any bank is open gives code 2. A legal one latches the burst length from addr[2:0]: 000=1, 001=2, 010=4, 011=8, 111=256 beats, any other value 1 beat.
- R6: After a legal mode-register write at edge t, any command other than deselect or no-operation during the following MRD_CYCLES-1 edges (edge t+1 for the default of 2) gives code 1.
- R7: Refresh while any bank is open gives code 3; with all banks closed it is legal.
- R8: A legal read or write with addr[10]=1 at edge t starts an auto-precharge burst of BL beats. Any read or write at edges t+1..t+BL-1 gives code 6; the bank stays open through edge t+BL-1 and is closed from edge t+BL on.
- R9: Burst stop is never flagged outside the R6 window, for every burst length and whether or not a burst is running, and it changes no state.
- R10: A flagged command changes neither the bank states, nor the burst length, nor any running burst.
- R11: A synchronous active-low reset closes all banks, ends any lockout and burst, sets the burst length to 1 beat and holds viol low with viol_code 0.
- R12: When several rules apply, code 1 wins over every other code, and for reads and writes code 6 wins over code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus; bit 10 auto-precharge / all-banks, bits 2:0 burst-length code |
| viol | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | 0 none, 1 lockout, 2 mode write with open bank, 3 refresh with open bank, 4 activate open bank, 5 access closed bank, 6 access during auto-precharge burst |

## Verification
The bench walks every burst-length code through an auto-precharge burst and probes each edge of it, since an off-by-one in the burst counter would either close the bank one edge early (an activate at the last busy edge passes) or keep the lock one edge too long (the first legal access is flagged). It sweeps activate, access and single-bank precharge over all four banks so that a wrong bank index shows up as an access flagged on the wrong bank. It checks that a refused mode-register write leaves the old burst length in place, that a precharge ends a running burst early, and that the lockout code wins over the closed-bank code; a design that updated state on illegal commands or ranked codes differently would report another code at those points.

// File: rtl/sdram_chk_pkg.sv
`timescale 1ns/1ps
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_BST
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_LOCK     = 3'd1,
        ERR_MRS_OPEN = 3'd2,
        ERR_REF_OPEN = 3'd3,
        ERR_ACT_OPEN = 3'd4,
        ERR_RW_SHUT  = 3'd5,
        ERR_RW_AP    = 3'd6
    } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_BST;
            endcase
        end
    end

endmodule

// File: rtl/sdram_mrd_lock.sv
`timescale 1ns/1ps
module sdram_mrd_lock #(
    parameter int MRD_CYCLES = 2,
    localparam int CNT_W = $clog2(MRD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(MRD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/sdram_ap_tracker.sv
`timescale 1ns/1ps
module sdram_ap_tracker #(
    parameter int NUM_BANKS = 4,
    parameter int LEN_W     = 9,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BA_W-1:0] start_bank,
    input  logic            cancel,
    input  logic [LEN_W-1:0] burst_len,
    output logic            busy,
    output logic            done,
    output logic [BA_W-1:0] bank
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [BA_W-1:0]  bank;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.cnt  = burst_len - LEN_W'(1);
            st_d.bank = start_bank;
            done      = (burst_len == LEN_W'(1));
        end else if (cancel) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
            done     = (st_q.cnt == LEN_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);
    assign bank = start ? start_bank : st_q.bank;

endmodule

// File: rtl/sdram_cmd_checker.sv
`timescale 1ns/1ps
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 12,
    parameter int AP_BIT     = 10,
    parameter int COL_W      = 8,
    parameter int MRD_CYCLES = 2,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              viol,
    output logic [2:0]        viol_code
);

    localparam int LEN_W = COL_W + 1;
    localparam int BLC_W = 3;

    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
        logic [BLC_W-1:0]     blc;
        logic                 viol;
        err_e                 code;
    } state_t;

    state_t st_d, st_q;

    cmd_e             cmd;
    err_e             err;
    logic             legal;
    logic             ap_flag;
    logic             lock_busy;
    logic             lock_start;
    logic             ap_busy;
    logic             ap_done;
    logic             ap_start;
    logic             ap_cancel;
    logic [BA_W-1:0]  ap_bank;
    logic [LEN_W-1:0] beats;
    logic [NUM_BANKS-1:0] open_q;
    logic             unused_addr;

    assign unused_addr = ^addr;
    assign ap_flag     = addr[AP_BIT];
    assign open_q      = st_q.open;

    function automatic logic [LEN_W-1:0] beats_of(input logic [BLC_W-1:0] code);
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: beats_of = LEN_W'(1) << code;
            3'd7:                   beats_of = LEN_W'(1) << COL_W;
            default:                beats_of = LEN_W'(1);
        endcase
    endfunction

    assign beats = beats_of(st_q.blc);

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_mrd_lock #(
        .MRD_CYCLES (MRD_CYCLES)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lock_start),
        .busy  (lock_busy)
    );

    sdram_ap_tracker #(
        .NUM_BANKS (NUM_BANKS),
        .LEN_W     (LEN_W)
    ) u_ap (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ap_start),
        .start_bank (ba),
        .cancel     (ap_cancel),
        .burst_len  (beats),
        .busy       (ap_busy),
        .done       (ap_done),
        .bank       (ap_bank)
    );

    // Rule evaluation, lockout first
    always_comb begin
        err = ERR_NONE;
        if (lock_busy && (cmd != CMD_DESEL) && (cmd != CMD_NOP)) begin
            err = ERR_LOCK;
        end else begin
            case (cmd)
                CMD_ACT: if (st_q.open[ba]) err = ERR_ACT_OPEN;
                CMD_RD, CMD_WR: begin
                    if (ap_busy)              err = ERR_RW_AP;
                    else if (!st_q.open[ba])  err = ERR_RW_SHUT;
                end
                CMD_MRS: if (|st_q.open) err = ERR_MRS_OPEN;
                CMD_REF: if (|st_q.open) err = ERR_REF_OPEN;
                default: err = ERR_NONE;
            endcase
        end
    end

    assign legal      = (err == ERR_NONE);
    assign lock_start = legal && (cmd == CMD_MRS);
    assign ap_start   = legal && ap_flag && ((cmd == CMD_RD) || (cmd == CMD_WR));
    assign ap_cancel  = legal && (cmd == CMD_PRE) && ap_busy && (ap_flag || (ba == ap_bank));

    // Next-state of the bank model and the verdict registers
    always_comb begin
        st_d      = st_q;
        st_d.viol = !legal;
        st_d.code = err;
        if (ap_done) begin
            st_d.open[ap_bank] = 1'b0;
        end
        if (legal) begin
            case (cmd)
                CMD_ACT: st_d.open[ba] = 1'b1;
                CMD_PRE: begin
                    if (ap_flag) st_d.open     = '0;
                    else         st_d.open[ba] = 1'b0;
                end
                CMD_MRS: st_d.blc = addr[BLC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{open: '0, blc: '0, viol: 1'b0, code: ERR_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign viol      = st_q.viol;
    assign viol_code = st_q.code;

endmodule

// File: rtl/sdram_cmd_checker_sva.sv
`timescale 1ns/1ps
module sdram_cmd_checker_sva #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BA_W-1:0]      ba,
    input logic [ADDR_W-1:0]    addr,
    input logic                 viol,
    input logic [2:0]           viol_code,
    input logic                 lock_busy,
    input logic                 ap_busy,
    input logic [NUM_BANKS-1:0] open_banks
);

    logic quiet_cmd, is_act, is_rw, is_pre, is_ref, is_mrs, is_bst;

    assign quiet_cmd = cs_n || (ras_n && cas_n && we_n);
    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_rw  = !cs_n &&  ras_n && !cas_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_bst = !cs_n &&  ras_n &&  cas_n && !we_n;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!viol && viol_code == 3'd0)); // R11
    AST_QUIET_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) quiet_cmd |=> !viol); // R1
    AST_ACT_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n) (is_act && !lock_busy && open_banks[ba]) |=> (viol && viol_code == 3'd4)); // R2
    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (is_pre && addr[AP_BIT] && !lock_busy) |=> (open_banks == '0)); // R4
    AST_MRS_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n) (is_mrs && !lock_busy && open_banks != '0) |=> (viol && viol_code == 3'd2)); // R5
    AST_LOCKOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (lock_busy && !quiet_cmd) |=> (viol && viol_code == 3'd1)); // R6
    AST_REF_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n) (is_ref && !lock_busy && open_banks != '0) |=> (viol && viol_code == 3'd3)); // R7
    AST_AP_BURST_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (is_rw && !lock_busy && ap_busy) |=> (viol && viol_code == 3'd6)); // R8
    AST_BST_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n) (is_bst && !lock_busy) |=> !viol); // R9

endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .viol       (viol),
    .viol_code  (viol_code),
    .lock_busy  (lock_busy),
    .ap_busy    (ap_busy),
    .open_banks (open_q)
);

// File: tb/sim_sdram_cmd_checker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_checker;

    localparam logic [3:0] K_DES = 4'b1111;
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_MRS = 4'b0000;
    localparam logic [3:0] K_BST = 4'b0110;
    localparam logic [11:0] APB  = 12'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [11:0] addr = 12'd0;
    logic        viol;
    logic [2:0]  viol_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sdram_cmd_checker u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .viol      (viol),
        .viol_code (viol_code)
    );

    task automatic drive(input logic [3:0] k, input logic [1:0] b, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = k;
        ba   = b;
        addr = a;
    endtask

    // Drive at a falling edge, let the rising edge sample, check at the next falling edge
    task automatic step(input logic [3:0] k, input logic [1:0] b, input logic [11:0] a,
                        input logic [2:0] exp, input string tag);
        drive(k, b, a);
        @(negedge clk);
        n_tests++;
        if (viol !== (exp != 3'd0) || viol_code !== exp) begin
            n_fail++;
            $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
                     tag, viol, viol_code, (exp != 3'd0), exp);
        end
        drive(K_NOP, 2'd0, 12'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int codes [5] = '{0, 1, 2, 3, 7};
        @(negedge clk);
        // R11: illegal-looking traffic during reset is never flagged
        step(K_ACT, 2'd0, 12'd0, 3'd0, "R11 reset quiet");
        step(K_RD,  2'd1, 12'd0, 3'd0, "R11 reset quiet");
        rst_n = 1'b1;

        // R1: deselect and no-op never flagged
        step(K_DES, 2'd3, 12'hFFF, 3'd0, "R1 deselect");
        step(K_NOP, 2'd2, 12'hFFF, 3'd0, "R1 nop");

        // R2/R3: open banks one by one, probing access to every bank
        for (int b = 0; b < 4; b++) begin
            step(K_ACT, 2'(b), 12'd0, 3'd0, "R2 activate closed bank");
            for (int o = 0; o < 4; o++)
                step((o % 2 == 0) ? K_RD : K_WR, 2'(o), 12'd0,
                     (o <= b) ? 3'd0 : 3'd5, "R3 access vs bank state");
            step(K_ACT, 2'(b), 12'd0, 3'd4, "R2 activate open bank");
        end
        step(K_MRS, 2'd0, 12'd2, 3'd2, "R5 mode write with open banks");
        step(K_REF, 2'd0, 12'd0, 3'd3, "R7 refresh with open banks");
        step(K_PRE, 2'd2, APB, 3'd0, "R4 precharge all");
        for (int b = 0; b < 4; b++)
            step(K_RD, 2'(b), 12'd0, 3'd5, "R4 all banks closed");
        step(K_REF, 2'd0, 12'd0, 3'd0, "R7 refresh all closed");

        // R4: single-bank precharge sweep
        for (int b = 0; b < 4; b++) step(K_ACT, 2'(b), 12'd0, 3'd0, "R2 open all");
        for (int p = 0; p < 4; p++) begin
            step(K_PRE, 2'(p), 12'd0, 3'd0, "R4 precharge one");
            for (int q = 0; q < 4; q++)
                step(K_WR, 2'(q), 12'd0, (q <= p) ? 3'd5 : 3'd0, "R4 only selected bank closed");
        end

        // R6/R12: lockout after a mode write
        step(K_MRS, 2'd0, 12'd2, 3'd0, "R5 legal mode write");
        step(K_RD,  2'd0, 12'd0, 3'd1, "R12 lockout beats closed-bank");
        step(K_ACT, 2'd0, 12'd0, 3'd0, "R6 lockout over");
        step(K_MRS, 2'd0, 12'd0, 3'd2, "R10 refused mode write no lockout");
        step(K_ACT, 2'd1, 12'd0, 3'd0, "R10 refused mode write no lockout");
        step(K_PRE, 2'd0, APB, 3'd0, "R4 precharge all");
        step(K_MRS, 2'd0, 12'd0, 3'd0, "R5 legal mode write");
        step(K_DES, 2'd0, 12'd0, 3'd0, "R6 deselect in lockout");
        step(K_BST, 2'd0, 12'd0, 3'd0, "R9 burst stop after lockout");
        step(K_MRS, 2'd0, 12'd1, 3'd0, "R5 legal mode write");
        step(K_BST, 2'd0, 12'd0, 3'd1, "R6 burst stop in lockout");
        step(K_NOP, 2'd0, 12'd0, 3'd0, "R1 nop");

        // R8/R9: auto-precharge burst for every burst-length code
        for (int i = 0; i < 5; i++) begin
            int len;
            len = (codes[i] == 7) ? 256 : (1 << codes[i]);
            step(K_MRS, 2'd0, 12'(codes[i]), 3'd0, "R5 program burst length");
            step(K_NOP, 2'd0, 12'd0, 3'd0, "R1 nop");
            step(K_ACT, 2'd1, 12'd0, 3'd0, "R2 open bank 1");
            step((i % 2 == 0) ? K_RD : K_WR, 2'd1, APB, 3'd0, "R8 start auto-precharge burst");
            for (int k = 1; k < len; k++) begin
                if (k == len - 1)
                    step(K_ACT, 2'd1, 12'd0, 3'd4, "R8 bank open at last beat");
                else if (k % 3 == 0)
                    step(K_BST, 2'd1, 12'd0, 3'd0, "R9 burst stop during burst");
                else
                    step((k % 2 == 0) ? K_RD : K_WR, 2'(k % 4), 12'd0, 3'd6, "R8 access during burst");
            end
            step(K_ACT, 2'd1, 12'd0, 3'd0, "R8 bank closed after burst");
            step(K_PRE, 2'd0, APB, 3'd0, "R4 precharge all");
        end

        // R10: refused mode write keeps the old burst length
        step(K_MRS, 2'd0, 12'd0, 3'd0, "R5 burst length 1");
        step(K_NOP, 2'd0, 12'd0, 3'd0, "R1 nop");
        step(K_ACT, 2'd0, 12'd0, 3'd0, "R2 open bank 0");
        step(K_MRS, 2'd0, 12'd3, 3'd2, "R10 refused mode write");
        step(K_RD,  2'd0, APB, 3'd0, "R10 auto-precharge read");
        step(K_RD,  2'd0, 12'd0, 3'd5, "R10 length still 1");

        // R4: precharge ends a running burst
        step(K_MRS, 2'd0, 12'd2, 3'd0, "R5 burst length 4");
        step(K_NOP, 2'd0, 12'd0, 3'd0, "R1 nop");
        step(K_ACT, 2'd0, 12'd0, 3'd0, "R2 open bank 0");
        step(K_ACT, 2'd2, 12'd0, 3'd0, "R2 open bank 2");
        step(K_WR,  2'd0, APB, 3'd0, "R8 start burst");
        step(K_PRE, 2'd0, 12'd0, 3'd0, "R4 precharge burst bank");
        step(K_RD,  2'd2, 12'd0, 3'd0, "R4 burst ended by precharge");
        step(K_ACT, 2'd0, 12'd0, 3'd0, "R4 burst bank closed");

        // R11: reset mid-operation
        step(K_ACT, 2'd3, 12'd0, 3'd0, "R2 open bank 3");
        rst_n = 1'b0;
        step(K_ACT, 2'd3, 12'd0, 3'd0, "R11 reset quiet");
        rst_n = 1'b1;
        step(K_ACT, 2'd3, 12'd0, 3'd0, "R11 banks closed by reset");
        step(K_RD,  2'd3, APB, 3'd0, "R11 auto-precharge read");
        step(K_RD,  2'd3, 12'd0, 3'd5, "R11 length back to 1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule